// File: doc/BRIEF.md
# Self-Synchronizing Byte Stream Cipher

This block encrypts or decrypts a byte stream, one byte per write strobe. The output byte is the input byte XORed with an 8-bit keystream register and with an 8-bit key. The keystream register is not free-running. On each strobe it absorbs the ciphertext byte of that cycle. It ORs that byte into its current contents and then shifts right. The new top bit is an XOR of four taps of the ORed word.

The same block serves both ends of a link. In encrypt mode the register absorbs the byte the block computes. In decrypt mode it absorbs the ciphertext byte it receives. A sender and a receiver that start from the same seed and use the same key therefore track each other byte for byte. Because the register absorbs ciphertext, a receiver that has drifted after a transmission error is pulled back into step by the ciphertext itself. A ciphertext byte of all ones sets the register to one fixed value, whatever it held before.

The output is combinational from the current register, key and input byte. The register changes only on a clock edge where the strobe is high. Synchronous reset loads the seed.

Top module: `selfsync_cipher`

## Requirements
- R1: A clock edge with `rst_i` high loads the keystream register with the seed 8'h01, even if `wr_en_i` is also high. After reset, encrypt mode with `din_i` = 8'h00 and `key_i` = 8'h00 shows 8'h01 on `dout_o`.
- R2: In both modes, `dout_o` equals `din_i` XOR keystream XOR `key_i`, in the same cycle as the inputs.
- R3: On an edge with `wr_en_i` low, the keystream register keeps its value, whatever the other inputs are.
- R4: With `dec_i` = 0 (encrypt), the byte the register absorbs on a strobe is `dout_o`.
- R5: With `dec_i` = 1 (decrypt), the byte the register absorbs on a strobe is `din_i`.
- R6: On a strobe, with f = keystream OR absorbed byte, the next keystream is {f[0]^f[2]^f[3]^f[4], f[7:1]}. Bit 7 is the MSB.
- R7: A sender in encrypt mode and a receiver in decrypt mode, both starting from reset and given the same key sequence, return the original plaintext sequence when the receiver is fed the sender's ciphertext.
- R8: A strobe whose absorbed byte is 8'hFF leaves the keystream at 8'h7F, whatever it held before.
- R9: After a corrupted ciphertext byte, the receiver's output is again equal to the sender's plaintext from the byte after the next ciphertext byte of 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; loads the seed |
| wr_en_i | input | 1 | Byte strobe; the register advances on edges where it is high |
| dec_i | input | 1 | 0 = encrypt (absorb output byte), 1 = decrypt (absorb input byte) |
| din_i | input | 8 | Plaintext in encrypt mode, received ciphertext in decrypt mode |
| key_i | input | 8 | Key byte XORed into every output |
| dout_o | output | 8 | Ciphertext in encrypt mode, recovered plaintext in decrypt mode |

## Verification
`dout_o` is due in the same cycle its inputs are applied, because no register lies between the inputs and that output. A strobe's effect on the keystream shows only in the output of the cycle after the rising edge that takes it. The bench changes the inputs on each falling edge and reads `dout_o` 5 ns later, before the next rising edge. Each reading therefore reflects every strobe taken up to and including the previous edge. Register behaviour such as reset, hold and the 8'hFF resynchronization is checked by driving zero data and zero key in encrypt mode for one cycle, so that the output shows the register directly.

// File: rtl/selfsync_cipher_pkg.sv
package selfsync_cipher_pkg;

    localparam int unsigned CIPHER_W = 8;

    localparam logic [CIPHER_W-1:0] KS_SEED = 8'h01;

    // Taps that feed the new top bit: bit positions 0, 2, 3 and 4
    localparam logic [CIPHER_W-1:0] KS_TAPS = 8'b0001_1101;

    typedef enum logic {
        MODE_ENC = 1'b0,
        MODE_DEC = 1'b1
    } cipher_mode_e;

endpackage

// File: rtl/selfsync_ks_feedback.sv
module selfsync_ks_feedback #(
    parameter int unsigned W        = selfsync_cipher_pkg::CIPHER_W,
    parameter logic [W-1:0] TAPS    = selfsync_cipher_pkg::KS_TAPS
) (
    input  logic [W-1:0] ks_i,
    input  logic [W-1:0] absorb_i,
    output logic [W-1:0] ks_next_o
);

    logic [W-1:0] merged;
    logic [W:0]   par_chain;

    assign merged       = ks_i | absorb_i;
    assign par_chain[0] = 1'b0;

    // Fold the tapped bits one at a time into a parity chain
    for (genvar gi = 0; gi < W; gi++) begin : g_tap
        if (TAPS[gi]) begin : g_on
            assign par_chain[gi+1] = par_chain[gi] ^ merged[gi];
        end else begin : g_off
            assign par_chain[gi+1] = par_chain[gi];
        end
    end

    assign ks_next_o = {par_chain[W], merged[W-1:1]};

endmodule

// File: rtl/selfsync_xor_path.sv
module selfsync_xor_path #(
    parameter int unsigned W = selfsync_cipher_pkg::CIPHER_W
) (
    input  logic [W-1:0]                     ks_i,
    input  logic [W-1:0]                     key_i,
    input  logic [W-1:0]                     din_i,
    input  selfsync_cipher_pkg::cipher_mode_e mode_i,
    output logic [W-1:0]                     dout_o,
    output logic [W-1:0]                     absorb_o
);

    logic [W-1:0] keyed;

    always_comb begin
        keyed  = ks_i ^ key_i;
        dout_o = keyed ^ din_i;
        // The register always absorbs the ciphertext side of the link
        if (mode_i == selfsync_cipher_pkg::MODE_DEC) begin
            absorb_o = din_i;
        end else begin
            absorb_o = dout_o;
        end
    end

endmodule

// File: rtl/selfsync_ks_reg.sv
module selfsync_ks_reg #(
    parameter int unsigned  W    = selfsync_cipher_pkg::CIPHER_W,
    parameter logic [W-1:0] SEED = selfsync_cipher_pkg::KS_SEED
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         adv_i,
    input  logic [W-1:0] ks_next_i,
    output logic [W-1:0] ks_o
);

    typedef struct packed {
        logic [W-1:0] ks;
    } ks_state_t;

    ks_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.ks = ks_next_i;
        end
        if (rst_i) begin
            st_d.ks = SEED;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign ks_o = st_q.ks;

endmodule

// File: rtl/selfsync_cipher.sv
module selfsync_cipher #(
    parameter int unsigned  W    = selfsync_cipher_pkg::CIPHER_W,
    parameter logic [W-1:0] SEED = selfsync_cipher_pkg::KS_SEED,
    parameter logic [W-1:0] TAPS = selfsync_cipher_pkg::KS_TAPS
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         wr_en_i,
    input  logic         dec_i,
    input  logic [W-1:0] din_i,
    input  logic [W-1:0] key_i,
    output logic [W-1:0] dout_o
);

    logic [W-1:0] ks_q;
    logic [W-1:0] ks_next;
    logic [W-1:0] absorb;
    selfsync_cipher_pkg::cipher_mode_e mode;

    assign mode = dec_i ? selfsync_cipher_pkg::MODE_DEC : selfsync_cipher_pkg::MODE_ENC;

    selfsync_xor_path #(.W(W)) xor_i (
        .ks_i     (ks_q),
        .key_i    (key_i),
        .din_i    (din_i),
        .mode_i   (mode),
        .dout_o   (dout_o),
        .absorb_o (absorb)
    );

    selfsync_ks_feedback #(.W(W), .TAPS(TAPS)) fb_i (
        .ks_i      (ks_q),
        .absorb_i  (absorb),
        .ks_next_o (ks_next)
    );

    selfsync_ks_reg #(.W(W), .SEED(SEED)) reg_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .adv_i     (wr_en_i),
        .ks_next_i (ks_next),
        .ks_o      (ks_q)
    );

endmodule

// File: rtl/selfsync_cipher_chk.sv
module selfsync_cipher_chk #(
    parameter int unsigned  W    = 8,
    parameter logic [W-1:0] SEED = 8'h01,
    parameter logic [W-1:0] TAPS = 8'b0001_1101
) (
    input logic         clk,
    input logic         rst,
    input logic         wr,
    input logic         dec,
    input logic [W-1:0] din,
    input logic [W-1:0] key,
    input logic [W-1:0] dout,
    input logic [W-1:0] state
);

    logic past_rst_q = 1'b0;

    always_ff @(posedge clk) begin
        past_rst_q <= rst;
    end

    function automatic logic [W-1:0] step_of(input logic [W-1:0] z, input logic [W-1:0] c);
        logic [W-1:0] m;
        m = z | c;
        return {^(m & TAPS), m[W-1:1]};
    endfunction

    AST_RESET_SEED: assert property (@(posedge clk) past_rst_q |-> (state == SEED)); // R1

    AST_OUT_XOR: assert property (@(posedge clk) disable iff (rst)
        dout == (din ^ key ^ state)); // R2

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(state)); // R3

    AST_STEP_ENC: assert property (@(posedge clk) disable iff (rst)
        (wr && !dec) |=> (state == step_of($past(state), $past(dout)))); // R4

    AST_STEP_DEC: assert property (@(posedge clk) disable iff (rst)
        (wr && dec) |=> (state == step_of($past(state), $past(din)))); // R5

    AST_ALL_ONES_RESYNC: assert property (@(posedge clk) disable iff (rst)
        (wr && ((dec ? din : dout) == {W{1'b1}})) |=> (state == {^TAPS, {(W-1){1'b1}}})); // R8

endmodule

bind selfsync_cipher selfsync_cipher_chk #(.W(W), .SEED(SEED), .TAPS(TAPS)) chk_i (
    .clk   (clk_i),
    .rst   (rst_i),
    .wr    (wr_en_i),
    .dec   (dec_i),
    .din   (din_i),
    .key   (key_i),
    .dout  (dout_o),
    .state (ks_q)
);

// File: tb/selfsync_cipher_tb.sv
module selfsync_cipher_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr;
    logic       dec;
    logic [7:0] din;
    logic [7:0] key;
    logic [7:0] dout;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    selfsync_cipher dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .wr_en_i (wr),
        .dec_i   (dec),
        .din_i   (din),
        .key_i   (key),
        .dout_o  (dout)
    );

    // {wr, dec, din, key, expected dout}, walked right after a reset
    localparam logic [25:0] VEC [0:6] = '{
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h01},  // R1 seed, R2, R6
        {1'b1, 1'b0, 8'h00, 8'h3C, 8'hBC},  // R2 key, R4
        {1'b1, 1'b0, 8'hA5, 8'h3C, 8'h47},  // R2, R6
        {1'b0, 1'b0, 8'h00, 8'h00, 8'h6F},  // R6 result, no strobe
        {1'b1, 1'b1, 8'h12, 8'h00, 8'h7D},  // R3 held, R5 decrypt absorb
        {1'b1, 1'b0, 8'hC0, 8'h00, 8'hFF},  // R5 result 3F, output FF
        {1'b0, 1'b0, 8'h00, 8'h00, 8'h7F}   // R8 forced state
    };

    function automatic logic [7:0] ref_next(input logic [7:0] z, input logic [7:0] c);
        logic [7:0] f;
        f = z | c;
        return {f[0] ^ f[2] ^ f[3] ^ f[4], f[7:1]};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive on the falling edge, settle, then read the output
    task automatic apply(input logic w, input logic d, input logic [7:0] di, input logic [7:0] k);
        @(negedge clk);
        wr  = w;
        dec = d;
        din = di;
        key = k;
        #5;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr  = 1'b1;
        dec = 1'b0;
        din = 8'h5A;
        key = 8'hC3;
        @(negedge clk);
        rst = 1'b0;
        wr  = 1'b0;
    endtask

    logic [7:0] ptxt [0:15];
    logic [7:0] ctxt [0:15];
    logic [7:0] kseq [0:15];

    initial begin
        rst = 1'b1;
        wr  = 1'b0;
        dec = 1'b0;
        din = 8'h00;
        key = 8'h00;
        repeat (2) @(posedge clk);

        // R1: reset with a strobe and junk data still yields the seed
        do_reset();
        apply(1'b0, 1'b0, 8'h00, 8'h00);
        check("R1", dout, 8'h01);

        // Vector table
        do_reset();
        for (int i = 0; i < 7; i++) begin
            apply(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
            check("R2/R4/R5/R6/R8 table", dout, VEC[i][7:0]);
        end

        // R3: several non-strobe cycles with busy inputs leave state 7F
        apply(1'b0, 1'b1, 8'hAA, 8'h55);
        check("R3", dout, 8'h80);
        apply(1'b0, 1'b0, 8'hFF, 8'hFF);
        check("R3", dout, 8'h7F);
        apply(1'b0, 1'b0, 8'h00, 8'h00);
        check("R3", dout, 8'h7F);

        // R8: all-ones absorbed from an arbitrary state, in decrypt mode
        apply(1'b1, 1'b1, 8'h3A, 8'h00);
        apply(1'b1, 1'b1, 8'hFF, 8'h9E);
        apply(1'b0, 1'b0, 8'h00, 8'h00);
        check("R8", dout, 8'h7F);

        // R7: encrypt a sequence, then decrypt it from reset
        begin
            logic [7:0] z;
            z = 8'h01;
            do_reset();
            for (int i = 0; i < 16; i++) begin
                ptxt[i] = 8'(i * 37 + 5);
                kseq[i] = 8'(i * 11 + 3);
                apply(1'b1, 1'b0, ptxt[i], kseq[i]);
                ctxt[i] = dout;
                check("R2/R4 encrypt", dout, ptxt[i] ^ kseq[i] ^ z);
                z = ref_next(z, ptxt[i] ^ kseq[i] ^ z);
            end
            do_reset();
            for (int i = 0; i < 16; i++) begin
                apply(1'b1, 1'b1, ctxt[i], kseq[i]);
                check("R7", dout, ptxt[i]);
            end
        end

        // R9: corrupted byte 2, all-ones ciphertext at byte 6
        begin
            logic [7:0] z;
            z = 8'h01;
            do_reset();
            for (int i = 0; i < 12; i++) begin
                kseq[i] = 8'(i * 29 + 1);
                ptxt[i] = (i == 6) ? (8'hFF ^ z ^ kseq[i]) : 8'(i * 53 + 9);
                apply(1'b1, 1'b0, ptxt[i], kseq[i]);
                ctxt[i] = dout;
                z = ref_next(z, ptxt[i] ^ kseq[i] ^ z);
            end
            check("R9 sync byte", ctxt[6], 8'hFF);
            do_reset();
            for (int i = 0; i < 12; i++) begin
                apply(1'b1, 1'b1, (i == 2) ? (ctxt[i] ^ 8'h10) : ctxt[i], kseq[i]);
                if (i == 2) check("R9 corrupted byte", dout, ptxt[i] ^ 8'h10);
                if (i >= 7) check("R9", dout, ptxt[i]);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: dout=%h expected=completion", dout);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule